// File: doc/BRIEF.md
# Field-Encoded Multifunction ALU

This block is the arithmetic and logic unit of a single-cycle processor datapath. It is purely combinational: two operands and a five-bit function code go in, and a result word and four condition flags come out in the same cycle. No opcode is decoded inside. The function code is a set of small fields. Each field steers one piece of the datapath, so control logic upstream can drive the fields directly.

Four units work in parallel: an adder/subtractor, a bidirectional logarithmic shifter, a bitwise logic unit, and a set-less-than path that reuses the subtractor and its flags. The Math and Shft fields pick which unit drives the result. The Sub and Bool fields choose the variant inside that unit. The zero and negative flags describe the selected result. The carry and overflow flags always describe the adder/subtractor.

Top module: `falu_top`

## Requirements
- R1: The function code `fn_code` is split as bit 4 = Sub, bits 3:2 = Bool, bit 1 = Shft, bit 0 = Math. Math and Shft select the unit: 10 arithmetic, 11 compare, 01 shift, 00 logic.
- R2: With Math=1 and Shft=0, the result is A+B when Sub=0 and A-B when Sub=1, taken modulo 2^32.
- R3: With Math=1 and Shft=1, the result is 1 when A<B and 0 otherwise. Bool bit 0 = 0 compares as signed, Bool bit 0 = 1 compares as unsigned. Sub does not change the compare.
- R4: With Math=0 and Shft=1, the result is B shifted by A. Bool 00 or 01 shifts left with zero fill, Bool 10 shifts right with zero fill, and Bool 11 shifts right with copies of B's sign bit.
- R5: Only A[4:0] sets the shift amount. Higher bits of A have no effect on a shift result.
- R6: With Math=0 and Shft=0, the result is A AND B for Bool 00, A OR B for 01, A XOR B for 10 and NOR of A and B for 11.
- R7: `flag_z` is 1 exactly when the result is all zeros, and `flag_n` equals result bit 31, for every function code.
- R8: The adder subtracts when Sub=1 or when the code is a compare, and adds otherwise. `flag_c` is the borrow (A<B unsigned) when it subtracts and the carry out of A+B when it adds. `flag_v` is the signed overflow of that same operation. This holds for every function code.
- R9: All outputs follow input changes without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | Operand A; also the shift amount source |
| op_b | input | 32 | Operand B; the value shifted |
| fn_code | input | 5 | Function code {Sub, Bool[1:0], Shft, Math} |
| result | output | 32 | Selected unit output |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |
| flag_v | output | 1 | Signed overflow of the add/subtract |
| flag_c | output | 1 | Carry out (add) or borrow (subtract) |

## Verification
The bench builds the block with its default width of 32. At that width the shifter has five stages, so every shift distance from 0 to 31 is reachable, and the sign boundary at bit 31 lines up with the signed compare and the overflow flag. The bench applies all 32 function codes, including the undocumented-looking ones (a compare with Sub=0, a shift with Bool=01). Operands include 0, 1, the extreme signed values, all ones, and shift amounts just below and above 31. This covers wraparound, overflow of the less-than path and the fill behaviour of arithmetic right shifts.

// File: rtl/falu_pkg.sv
package falu_pkg;

    typedef struct packed {
        logic       sub;
        logic [1:0] bool_f;
        logic       shft;
        logic       math;
    } alu_fn_t;

    typedef enum logic [1:0] {
        UNIT_LOGIC = 2'b00,
        UNIT_SHIFT = 2'b01,
        UNIT_ARITH = 2'b10,
        UNIT_CMP   = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOR = 2'b11
    } logic_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } alu_flags_t;

    function automatic unit_e unit_of(input alu_fn_t f);
        return unit_e'({f.math, f.shft});
    endfunction

    function automatic logic subtracts(input alu_fn_t f);
        return f.sub | (f.math & f.shft);
    endfunction

endpackage

// File: rtl/falu_arith.sv
module falu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         cflag,
    output logic         lt_signed,
    output logic         lt_unsigned
);
    logic [W-1:0] b_eff;
    logic [W:0]   total;

    assign b_eff = sub_en ? ~b : b;
    assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
    assign sum   = total[W-1:0];

    // carry out of a + ~b + 1 is set when a >= b, so the borrow is its inverse
    assign cflag = sub_en ? ~total[W] : total[W];
    assign ovf   = (a[W-1] == b_eff[W-1]) & (sum[W-1] != a[W-1]);

    assign lt_signed   = sum[W-1] ^ ovf;
    assign lt_unsigned = cflag;
endmodule

// File: rtl/falu_shift.sv
module falu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    input  logic           go_right,
    input  logic           keep_sign,
    output logic [W-1:0]   out
);
    logic           fill;
    logic [W-1:0]   stg [SHW+1];

    assign fill   = keep_sign & val[W-1];
    assign stg[0] = val;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int D = 1 << i;
        logic [W-1:0] moved;
        assign moved = go_right ? {{D{fill}}, stg[i][W-1:D]}
                                : {stg[i][W-1-D:0], {D{1'b0}}};
        assign stg[i+1] = amt[i] ? moved : stg[i];
    end

    assign out = stg[SHW];
endmodule

// File: rtl/falu_logic.sv
module falu_logic
    import falu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_op_e    op,
    output logic [W-1:0] out
);
    always_comb begin
        unique case (op)
            LOP_AND: out = a & b;
            LOP_OR:  out = a | b;
            LOP_XOR: out = a ^ b;
            LOP_NOR: out = ~(a | b);
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/falu_top.sv
module falu_top
    import falu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [4:0]   fn_code,
    output logic [W-1:0] result,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_v,
    output logic         flag_c
);
    localparam int SHW = $clog2(W);

    alu_fn_t      fn;
    unit_e        unit;
    logic         do_sub;
    logic [W-1:0] sum_w, shf_w, log_w, cmp_w;
    logic         lt_s, lt_u;
    alu_flags_t   flg;

    assign fn     = alu_fn_t'(fn_code);
    assign unit   = unit_of(fn);
    assign do_sub = subtracts(fn);

    falu_arith #(.W(W)) u_arith (
        .a(op_a), .b(op_b), .sub_en(do_sub), .sum(sum_w),
        .ovf(flg.v), .cflag(flg.c), .lt_signed(lt_s), .lt_unsigned(lt_u)
    );

    falu_shift #(.W(W), .SHW(SHW)) u_shift (
        .val(op_b), .amt(op_a[SHW-1:0]), .go_right(fn.bool_f[1]),
        .keep_sign(fn.bool_f[0]), .out(shf_w)
    );

    falu_logic #(.W(W)) u_logic (
        .a(op_a), .b(op_b), .op(logic_op_e'(fn.bool_f)), .out(log_w)
    );

    assign cmp_w = {{(W-1){1'b0}}, (fn.bool_f[0] ? lt_u : lt_s)};

    always_comb begin
        unique case (unit)
            UNIT_ARITH: result = sum_w;
            UNIT_CMP:   result = cmp_w;
            UNIT_SHIFT: result = shf_w;
            UNIT_LOGIC: result = log_w;
            default:    result = '0;
        endcase
    end

    assign flg.z  = ~|result;
    assign flg.n  = result[W-1];
    assign flag_z = flg.z;
    assign flag_n = flg.n;
    assign flag_v = flg.v;
    assign flag_c = flg.c;
endmodule

// File: rtl/falu_chk.sv
module falu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [4:0]   fn_code,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_c
);
    always_comb begin
        if (fn_code[1:0] == 2'b11) begin
            // R3
            cmp_range_chk: assert (result[W-1:1] == '0);
            // R3
            if (fn_code[2]) begin
                unsigned_lt_chk: assert (result[0] == (op_a < op_b));
            end
        end
        // R2
        if (fn_code[1:0] == 2'b01 && !fn_code[4]) begin
            sum_chk: assert (result == op_a + op_b);
        end
        // R5
        if (fn_code[1:0] == 2'b10 && op_a[4:0] == 5'd0) begin
            shift_zero_chk: assert (result == op_b);
        end
        // R7
        if (flag_z) begin
            zero_sign_chk: assert (!flag_n);
        end
        // R8
        if (fn_code[4] || fn_code[1:0] == 2'b11) begin
            borrow_chk: assert (flag_c == (op_a < op_b));
        end
    end
endmodule

bind falu_top falu_chk #(.W(W)) u_chk (
    .op_a(op_a), .op_b(op_b), .fn_code(fn_code), .result(result),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
);

// File: tb/sim_falu_top.sv
`timescale 1ns/1ps
module sim_falu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = '0, b = '0;
    logic [4:0]  f = '0;
    logic [31:0] res;
    logic        z, n, v, c;
    int          applied = 0;
    int          bad = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    falu_top u0 (
        .op_a(a), .op_b(b), .fn_code(f), .result(res),
        .flag_z(z), .flag_n(n), .flag_v(v), .flag_c(c)
    );

    // {fn, a, b, expected}; fn = {Sub, Bool[1:0], Shft, Math} (R1)
    localparam logic [100:0] VEC [15] = '{
        {5'b00001, 32'h00000005, 32'h00000007, 32'h0000000C},  // R2 add
        {5'b10001, 32'h00000005, 32'h00000007, 32'hFFFFFFFE},  // R2 sub
        {5'b10011, 32'hFFFFFFFF, 32'h00000001, 32'h00000001},  // R3 signed
        {5'b10111, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},  // R3 unsigned
        {5'b00010, 32'h00000004, 32'h00000001, 32'h00000010},  // R4 left
        {5'b01010, 32'h00000004, 32'h80000000, 32'h08000000},  // R4 logical right
        {5'b01110, 32'h00000004, 32'h80000000, 32'hF8000000},  // R4 arith right
        {5'b00000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},  // R6 and
        {5'b00100, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0},  // R6 or
        {5'b01000, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0},  // R6 xor
        {5'b01100, 32'hF0F0F0F0, 32'hFF00FF00, 32'h000F000F},  // R6 nor
        {5'b00011, 32'h00000003, 32'h00000007, 32'h00000001},  // R3 with Sub=0
        {5'b00010, 32'h00000021, 32'h00000001, 32'h00000002},  // R5 upper bits ignored
        {5'b00110, 32'h00000001, 32'h00000001, 32'h00000002},  // R4 Bool=01 left
        {5'b10011, 32'h80000000, 32'h00000001, 32'h00000001}   // R3 across overflow
    };

    localparam logic [31:0] CORNER [7] = '{
        32'h00000000, 32'h00000001, 32'h7FFFFFFF, 32'h80000000,
        32'hFFFFFFFF, 32'h0000001F, 32'h00000020
    };

    // Reference model from the requirements: {result, z, n, v, c}
    function automatic logic [35:0] model(input logic [4:0] fc, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] r;
        logic        eff, vv, cc;
        longint      sx, sy, sr;
        eff = fc[4] | (fc[1] & fc[0]);
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        sr = eff ? sx - sy : sx + sy;
        vv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        cc = eff ? (x < y) : (({32'b0, x} + {32'b0, y}) > 64'h00000000FFFFFFFF);
        case ({fc[0], fc[1]})
            2'b10: r = eff ? x - y : x + y;
            2'b11: r = fc[2] ? {31'b0, x < y} : {31'b0, $signed(x) < $signed(y)};
            2'b01: begin
                if (!fc[3]) r = y << x[4:0];
                else if (fc[2]) r = $unsigned($signed(y) >>> x[4:0]);
                else r = y >> x[4:0];
            end
            default: case (fc[3:2])
                2'b00: r = x & y;
                2'b01: r = x | y;
                2'b10: r = x ^ y;
                default: r = ~(x | y);
            endcase
        endcase
        return {r, r == 32'd0, r[31], vv, cc};
    endfunction

    function automatic string op_tag(input logic [4:0] fc);
        case ({fc[0], fc[1]})
            2'b10: return "R2";
            2'b11: return "R3";
            2'b01: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s fn=%b a=%h b=%h actual=%h expected=%h", tag, f, a, b, act, exp);
        end
    endtask

    task automatic check_full();
        logic [35:0] e;
        e = model(f, a, b);
        check(op_tag(f), res, e[35:4]);
        check("R7", {30'b0, z, n}, {30'b0, e[3], e[2]});
        check("R8", {30'b0, v, c}, {30'b0, e[1], e[0]});
    endtask

    task automatic apply(input logic [4:0] fc, input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        f = fc; a = x; b = y;
        @(negedge clk);
        check_full();
    endtask

    initial begin
        // reset state: zero operands through AND give a zero result (R7)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", {31'b0, z}, 32'd1);
        check("R6", res, 32'd0);
        rst = 1'b0;

        // table walk (R1 layout)
        for (int i = 0; i < 15; i++) begin
            @(posedge clk);
            {f, a, b} = VEC[i][100:32];
            @(negedge clk);
            check(op_tag(f), res, VEC[i][31:0]);
            check_full();
        end

        // every code against corner operands
        for (int fc = 0; fc < 32; fc++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    apply(5'(fc), CORNER[i], CORNER[j]);

        // random operands over every code
        for (int k = 0; k < 2000; k++)
            apply(5'(k % 32), $urandom, $urandom);

        // R5: high bits of A never change a shift
        for (int k = 0; k < 8; k++) begin
            logic [31:0] x, y, r0;
            x = $urandom; y = $urandom;
            apply(5'b01110, {27'b0, x[4:0]}, y);
            r0 = res;
            apply(5'b01110, x, y);
            check("R5", res, r0);
        end

        // R9: outputs follow inputs with no clock edge in between
        @(negedge clk);
        f = 5'b00001; a = 32'd10; b = 32'd20;
        #1 check("R9", res, 32'd30);
        a = 32'hFFFFFFFF; b = 32'd1;
        #1 check("R9", {res[31:0]}, 32'd0);
        check("R8", {31'b0, c}, 32'd1);
        f = 5'b01100; a = 32'd0; b = 32'd0;
        #1 check("R9", res, 32'hFFFFFFFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            applied++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end
endmodule